// File: doc/BRIEF.md
# Lockable Watchdog Timer with Selectable Expiry Response

This block is a watchdog peripheral on a simple register bus. Software uses two registers. The first is an 8-bit control register that holds an enable, a response code, a lock and a timeout period. The second is a counter register. Any write to the counter register clears the running count, and this is the service ("kick") operation. While the watchdog is enabled, the count advances once per clock. If software fails to kick the block before the count reaches the end of the selected interval, the block fires. It then drives one of three outputs for a single clock cycle: a fast interrupt request, an external reset request or a system reset request.

The timeout is a power of two, 2^(BASE_EXP + STEP_EXP*P) cycles, where P is the 3-bit period field. With the default parameters, P=0 gives 2^17 cycles and P=4 gives 2^25 cycles. The usual bring-up sequence is to kick the counter and then write the whole control byte in one access. If that byte sets both the lock and the enable, the configuration is frozen until the next hardware reset.

Top module: `wdt_lockable`

## Requirements
- R1: After reset, the control register reads 0, the counter reads 0 and all three expiry outputs are low.
- R2: While control bit 0 (enable) is 0, the count does not change except through a kick, and no expiry output is asserted.
- R3: Take the edge that enables the block, or the edge of the last kick, as edge 0. With period field P in control bits 6:4, the expiry output is high in the cycle after edge 2^(BASE_EXP + STEP_EXP*P).
- R4: Control bits 2:1 select the output that fires. Codes 00 and 01 select the fast interrupt, 10 selects the external reset and 11 selects the system reset. Only that output goes high, for exactly one cycle.
- R5: On expiry the count returns to zero and keeps running, so expiry repeats every interval while the block stays unserviced.
- R6: A write to offset 0x34 (counter register) clears the count to zero whatever the data. When it coincides with the terminal count, no expiry occurs.
- R7: Once the stored control value has both bit 3 (lock) and bit 0 (enable) set, control writes are ignored until reset. Kicks still work while the lock holds.
- R8: A read is a one-cycle access: bus_rdata holds, in the following cycle, the control value from offset 0x30 with bit 7 as 0, the count from offset 0x34 zero-extended to 32 bits, or 0 for any other offset.
- R9: A control value with the lock bit set but the enable clear does not lock, so a later control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data; control uses bits 7:0 |
| bus_rdata | output | DATA_W | Registered read data |
| fiq_o | output | 1 | Fast interrupt request pulse |
| ext_rst_o | output | 1 | External reset request pulse |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
A count that is off by even one step moves the expiry pulse by a cycle against the computed interval. A count that stops entirely is visible on the next counter read. A wrongly decoded response code or a stale pulse register shows on the wrong output, or as a pulse wider than one cycle, in the very cycle the block fires. A lock flag that fails to set or clear shows as a changed or unchanged control read-back one cycle after the following control write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTRL_OFS = 'h30;
  localparam int unsigned CNT_OFS  = 'h34;
  localparam int unsigned PER_W    = 3;
  localparam int unsigned NUM_OUT  = 3;   // bit0 fast irq, bit1 external, bit2 system

  typedef enum logic [1:0] {
    RSP_FIQ = 2'b00,
    RSP_RSV = 2'b01,
    RSP_EXT = 2'b10,
    RSP_SYS = 2'b11
  } rsp_e;

  typedef struct packed {
    logic             spare;
    logic [PER_W-1:0] period;
    logic             lock;
    rsp_e             rsp;
    logic             en;
  } ctrl_t;

  function automatic logic [NUM_OUT-1:0] rsp_onehot(input rsp_e r);
    case (r)
      RSP_EXT: rsp_onehot = 3'b010;
      RSP_SYS: rsp_onehot = 3'b100;
      default: rsp_onehot = 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wbyte,
  output ctrl_t      ctrl_q,
  output logic       locked
);
  ctrl_t nxt;

  assign locked = ctrl_q.lock & ctrl_q.en;

  always_comb begin
    nxt       = ctrl_t'(wbyte);
    nxt.spare = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr && !locked)
      ctrl_q <= nxt;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned STEP_EXP = 2,
  parameter int unsigned CNT_W    = 31
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             kick,
  input  logic [PER_W-1:0] period,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  localparam int unsigned NPER = 1 << PER_W;

  logic [CNT_W-1:0] lim [NPER];
  logic             at_end;

  for (genvar g = 0; g < NPER; g++) begin : g_lim
    assign lim[g] = CNT_W'((64'd1 << (BASE_EXP + STEP_EXP * g)) - 64'd1);
  end

  assign at_end = (count_q == lim[period]);
  assign expire = en && at_end && !kick;

  always_ff @(posedge clk) begin
    if (rst || kick)
      count_q <= '0;
    else if (en)
      count_q <= at_end ? '0 : count_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  rsp_e               rsp,
  output logic [NUM_OUT-1:0] pulse_q
);
  logic [NUM_OUT-1:0] sel;

  assign sel = rsp_onehot(rsp);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst)
        pulse_q[k] <= 1'b0;
      else
        pulse_q[k] <= fire & sel[k];
    end
  end
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BASE_EXP = 17,
  parameter int unsigned STEP_EXP = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fiq_o,
  output logic              ext_rst_o,
  output logic              sys_rst_o
);
  localparam int unsigned CNT_W = BASE_EXP + STEP_EXP * ((1 << PER_W) - 1);

  ctrl_t              ctrl_q;
  logic               locked;
  logic [CNT_W-1:0]   count_q;
  logic               expire;
  logic               kick;
  logic               ctrl_wr;
  logic               hit_ctrl;
  logic               hit_cnt;
  logic [NUM_OUT-1:0] pulses;

  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_cnt  = (bus_addr == ADDR_W'(CNT_OFS));
  assign kick     = bus_wr && hit_cnt;
  assign ctrl_wr  = bus_wr && hit_ctrl;

  wdt_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctrl_wr),
    .wbyte  (bus_wdata[7:0]),
    .ctrl_q (ctrl_q),
    .locked (locked)
  );

  wdt_count #(
    .BASE_EXP (BASE_EXP),
    .STEP_EXP (STEP_EXP),
    .CNT_W    (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .en      (ctrl_q.en),
    .kick    (kick),
    .period  (ctrl_q.period),
    .count_q (count_q),
    .expire  (expire)
  );

  wdt_resp u_resp (
    .clk     (clk),
    .rst     (rst),
    .fire    (expire),
    .rsp     (ctrl_q.rsp),
    .pulse_q (pulses)
  );

  assign fiq_o     = pulses[0];
  assign ext_rst_o = pulses[1];
  assign sys_rst_o = pulses[2];

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd) begin
      if (hit_ctrl)
        bus_rdata <= DATA_W'(8'(ctrl_q));
      else if (hit_cnt)
        bus_rdata <= DATA_W'(count_q);
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/wdt_lockable_chk.sv
module wdt_lockable_chk #(
  parameter int unsigned CNT_W = 31
)(
  input logic             clk,
  input logic             rst,
  input logic             kick,
  input logic [7:0]       ctrl_bits,
  input logic [CNT_W-1:0] count,
  input logic             fiq_o,
  input logic             ext_rst_o,
  input logic             sys_rst_o
);
  // R4
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_rst_o, ext_rst_o, fiq_o}));

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || ext_rst_o || sys_rst_o) |=> !(fiq_o || ext_rst_o || sys_rst_o));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fiq_o || ext_rst_o || sys_rst_o) |-> (count == '0));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_bits[0] && !kick) |=> $stable(count));

  // R6
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == '0));

  // R7
  lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_bits[3] && ctrl_bits[0]) |=> $stable(ctrl_bits));

  // R8
  spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_bits[7] == 1'b0);
endmodule

bind wdt_lockable wdt_lockable_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .kick      (kick),
  .ctrl_bits (ctrl_q),
  .count     (count_q),
  .fiq_o     (fiq_o),
  .ext_rst_o (ext_rst_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/wdt_lockable_test.sv
`timescale 1ns/1ps
module wdt_lockable_test;
  localparam int unsigned BASE = 4;
  localparam int unsigned STEP = 2;
  localparam logic [7:0] A_CTRL = 8'h30;
  localparam logic [7:0] A_CNT  = 8'h34;

  // {period[2:0], rsp[1:0], expected {sys,ext,fiq}}
  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b000_00_001, 8'b001_01_001, 8'b000_10_010,
    8'b010_11_100, 8'b011_00_001, 8'b001_10_010
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fiq_o, ext_rst_o, sys_rst_o;

  int nchk = 0;
  int nfail = 0;
  int first_i, second_i, highs;
  logic [2:0] first_v;

  always #2 clk = ~clk;

  wdt_lockable #(.BASE_EXP(BASE), .STEP_EXP(STEP)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fiq_o(fiq_o), .ext_rst_o(ext_rst_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_reset();
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic watch(input int n);
    first_i = 0; second_i = 0; highs = 0; first_v = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if ({sys_rst_o, ext_rst_o, fiq_o} != 3'b000) begin
        highs++;
        if (first_i == 0) begin
          first_i = i; first_v = {sys_rst_o, ext_rst_o, fiq_o};
        end else if (second_i == 0) second_i = i;
      end
    end
  endtask

  function automatic int period_len(input int p);
    return 1 << (BASE + STEP * p);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int len;
    do_reset();

    // R1 reset state
    check("R1 outputs", {29'd0, sys_rst_o, ext_rst_o, fiq_o}, 32'd0);
    rd(A_CTRL, d); check("R1 ctrl", d, 32'd0);
    rd(A_CNT, d);  check("R1 count", d, 32'd0);

    // R2 disabled: no counting, no pulse
    wr(A_CTRL, 32'h40);
    watch(40);
    check("R2 no pulse", highs, 0);
    rd(A_CNT, d);  check("R2 count held", d, 32'd0);
    rd(A_CTRL, d); check("R8 ctrl readback", d, 32'h40);

    // R3 / R4 table of periods and responses
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] per;
      logic [1:0] rsp;
      per = VEC[v][7:5];
      rsp = VEC[v][4:3];
      len = period_len(int'(per));
      do_reset();
      wr(A_CNT, 32'd0);
      wr(A_CTRL, {24'd0, 1'b0, per, 1'b0, rsp, 1'b1});
      watch(len + 3);
      check("R3 expiry cycle", first_i, len);
      check("R4 output select", {29'd0, first_v}, {29'd0, VEC[v][2:0]});
      check("R4 single pulse", highs, 1);
    end

    // R5 wrap and repeat
    do_reset();
    wr(A_CTRL, 32'h01);
    watch(2 * 16 + 2);
    check("R5 first", first_i, 16);
    check("R5 second", second_i, 32);
    check("R5 count", highs, 2);

    // R6 kick restarts interval
    do_reset();
    wr(A_CTRL, 32'h05);
    repeat (10) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      wr(A_CNT, 32'hDEAD_BEEF);
      watch(12);
      check("R6 kicked no pulse", highs, 0);
    end
    wr(A_CNT, 32'd0);
    watch(19);
    check("R6 interval after kick", first_i, 16);
    check("R6 ext output", {29'd0, first_v}, 32'd2);

    // R8 running count and unmapped offset
    do_reset();
    wr(A_CTRL, 32'h01);
    repeat (4) @(negedge clk);
    rd(A_CNT, d);  check("R8 count readback", d, 32'd4);
    rd(8'h10, d);  check("R8 unmapped", d, 32'd0);
    rd(A_CTRL, d); check("R8 ctrl", d, 32'h01);

    // R9 lock without enable does not lock; R8 bit 7 reads zero
    do_reset();
    wr(A_CTRL, 32'hFE);
    rd(A_CTRL, d); check("R8 bit7 zero", d, 32'h7E);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, d); check("R9 not locked", d, 32'h00);

    // R7 lock
    do_reset();
    wr(A_CTRL, 32'h0F);
    wr(A_CTRL, 32'h00);
    rd(A_CTRL, d); check("R7 write ignored", d, 32'h0F);
    wr(A_CNT, 32'd0);
    watch(19);
    check("R7 kick works", first_i, 16);
    check("R7 sys output", {29'd0, first_v}, 32'd4);
    do_reset();
    rd(A_CTRL, d); check("R7 reset unlocks", d, 32'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule